// File: doc/BRIEF.md
# Receive FIFO with trigger, idle timeout and flow control

This block sits behind the bit sampler of a serial receiver. Each deserialised character arrives as a one-cycle strobe with a data byte and two line-condition flags: framing error and break. The block stores it in a 64-entry queue. The reader sees the oldest entry as a 32-bit word that packs the byte, an empty marker and both flags. A read strobe removes that entry from the queue.

The block derives three interrupt events from the queue state and from line activity:
- a fill-level trigger with a selectable threshold,
- an inactivity timeout, counted in character times, that catches small leftovers which never reach the trigger,
- a one-cycle overrun pulse when a character arrives with no room left.

A flow-control output tells the far end to pause once the fill passes a second selectable threshold. All settings come from one 32-bit control word. The field positions are fixed so that the register file can drive the word directly. The block also passes a 5-bit sampling-phase field through to the bit sampler.

Top module: `hsrx_queue`

## Requirements
- R1: The read word carries the data byte in bits [7:0], the framing-error flag in bit 9 and the break flag in bit 10. Bit 8 is 0 when an entry is present, and bits [31:11] are always 0.
- R2: When the queue is empty, the read word is 0x00000100: bit 8 set, byte zero and both flags clear. A read strobe while empty leaves the fill and the order of later entries unchanged.
- R3: Entries leave in arrival order. The queue holds 64 entries, and fill_level reports the entry count one cycle after each accepted write or read.
- R4: A character that arrives while the queue holds 64 entries is discarded. In that case overrun_irq is high for exactly the following cycle.
- R5: trig_irq is a level, high whenever the fill is at or above the threshold selected by ctrl[4:2]. Codes 0 to 5 select 1, 4, 8, 16, 32 and 48 entries; codes 6 and 7 also select 48.
- R6: ctrl[17:16] selects the timeout: 0 disables it, and 1, 2 and 3 select 4, 8 and 16 character times. One character time is 10 bit periods of 14 os_tick pulses each, so 140 ticks.
- R7: The timeout count restarts on every incoming character strobe and on every read strobe. timeout_irq is high only while the queue is non-empty, and it stays high until the next restart.
- R8: ctrl[18] enables flow control and ctrl[20:19] selects a threshold of 8, 16, 32 or 48 entries. Before inversion, rts_out is 1 while the fill is below the threshold and 0 at or above it; with flow control disabled it is 1. ctrl[21] inverts the output.
- R9: sample_phase always equals ctrl[13:9].
- R10: After reset the queue is empty and fill_level, trig_irq, timeout_irq and overrun_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample tick, 14 per bit period |
| rx_valid | input | 1 | Strobe: a character has been deserialised |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error seen on this character |
| rx_brk | input | 1 | Break condition seen on this character |
| ctrl | input | 32 | Control word |
| rd_en | input | 1 | Read strobe: removes the head entry |
| rd_word | output | 32 | Packed head entry |
| fill_level | output | 7 | Number of stored entries |
| trig_irq | output | 1 | Fill at or above the trigger threshold |
| timeout_irq | output | 1 | Inactivity timeout with data waiting |
| overrun_irq | output | 1 | One-cycle pulse after a discarded character |
| rts_out | output | 1 | Flow-control output |
| sample_phase | output | 5 | Sampling offset for the bit sampler |

## Verification
A pointer or count fault first shows at rd_word and fill_level. A skipped, repeated or out-of-order byte appears during the drain of a full queue, within one read of the faulty step. A stuck or misdecoded threshold flips trig_irq or rts_out in the same cycle as the fill crosses it. A timer that miscounts moves the rise of timeout_irq away from the expected character-time boundary, by at least one character time (140 cycles with a tick on every clock). A full-queue write that is not discarded shows as a wrong fill or as a foreign byte in the drain order.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;

  localparam int WORD_W    = 32;
  localparam int EMPTY_BIT = 8;
  localparam int FERR_BIT  = 9;
  localparam int BRK_BIT   = 10;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_char_t;

  // fill threshold for the receive trigger, codes 6/7 saturate at 48
  function automatic logic [7:0] trig_fill(input logic [2:0] sel);
    case (sel)
      3'd0:    return 8'd1;
      3'd1:    return 8'd4;
      3'd2:    return 8'd8;
      3'd3:    return 8'd16;
      3'd4:    return 8'd32;
      default: return 8'd48;
    endcase
  endfunction

  // fill at which flow control tells the far end to pause
  function automatic logic [7:0] flow_fill(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd8;
      2'd1:    return 8'd16;
      2'd2:    return 8'd32;
      default: return 8'd48;
    endcase
  endfunction

  // inactivity limit in character times, 0 means disabled
  function automatic logic [4:0] idle_chars(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd0;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic empty, input rx_char_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    if (empty) begin
      w[EMPTY_BIT] = 1'b1;
    end else begin
      w[7:0]      = c.data;
      w[FERR_BIT] = c.ferr;
      w[BRK_BIT]  = c.brk;
    end
    return w;
  endfunction

endpackage

// File: rtl/hsrx_store.sv
module hsrx_store
  import hsrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  rx_char_t      wr_char,
  input  logic          rd_req,
  output rx_char_t      head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);

  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic            do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_req && !full;
  assign do_rd = rd_req && !empty;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/hsrx_idle_timer.sv
module hsrx_idle_timer
  import hsrx_pkg::*;
#(
  parameter int OVERSAMPLE = 14,
  parameter int CHAR_BITS  = 10,
  localparam int TPC = OVERSAMPLE * CHAR_BITS,
  localparam int TW  = $clog2(TPC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       restart,
  input  logic [1:0] sel,
  input  logic       occupied,
  output logic       expired
);

  logic [TW-1:0] tick_cnt;
  logic [4:0]    chars;
  logic [4:0]    limit;
  logic          char_done;

  assign limit     = idle_chars(sel);
  assign char_done = os_tick && (tick_cnt == TW'(TPC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      chars    <= '0;
    end else if (restart) begin
      tick_cnt <= '0;
      chars    <= '0;
    end else if (os_tick) begin
      if (char_done) begin
        tick_cnt <= '0;
        if (chars != 5'd16) chars <= chars + 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assign expired = (sel != 2'd0) && occupied && (chars >= limit);

endmodule

// File: rtl/hsrx_flow.sv
module hsrx_flow
  import hsrx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] level,
  input  logic [2:0]    trig_sel,
  input  logic          flow_en,
  input  logic [1:0]    flow_sel,
  input  logic          flow_inv,
  output logic          trig_hit,
  output logic          rts_out
);

  logic [7:0] lvl8;
  logic       room;

  assign lvl8     = 8'(level);
  assign trig_hit = (lvl8 >= trig_fill(trig_sel));
  assign room     = !flow_en || (lvl8 < flow_fill(flow_sel));
  assign rts_out  = room ^ flow_inv;

endmodule

// File: rtl/hsrx_queue.sv
module hsrx_queue
  import hsrx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int OVERSAMPLE = 14,
  parameter int CHAR_BITS  = 10,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic [31:0]   ctrl,
  input  logic          rd_en,
  output logic [31:0]   rd_word,
  output logic [CW-1:0] fill_level,
  output logic          trig_irq,
  output logic          timeout_irq,
  output logic          overrun_irq,
  output logic          rts_out,
  output logic [4:0]    sample_phase
);

  // decoded control fields
  logic [2:0] trig_sel;
  logic [1:0] idle_sel;
  logic       flow_en;
  logic [1:0] flow_sel;
  logic       flow_inv;
  logic       unused_ctrl;

  assign trig_sel     = ctrl[4:2];
  assign idle_sel     = ctrl[17:16];
  assign flow_en      = ctrl[18];
  assign flow_sel     = ctrl[20:19];
  assign flow_inv     = ctrl[21];
  assign sample_phase = ctrl[13:9];
  assign unused_ctrl  = ^{ctrl[31:22], ctrl[15:14], ctrl[8:5], ctrl[1:0]};

  // internal events, named for the checker
  rx_char_t in_char;
  rx_char_t head;
  logic     q_full, q_empty;
  logic     drop_evt;
  logic     restart_evt;

  assign in_char     = '{brk: rx_brk, ferr: rx_ferr, data: rx_data};
  assign drop_evt    = rx_valid && q_full;
  assign restart_evt = rx_valid || rd_en;

  hsrx_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (rx_valid),
    .wr_char (in_char),
    .rd_req  (rd_en),
    .head    (head),
    .level   (fill_level),
    .full    (q_full),
    .empty   (q_empty)
  );

  hsrx_idle_timer #(.OVERSAMPLE(OVERSAMPLE), .CHAR_BITS(CHAR_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .os_tick  (os_tick),
    .restart  (restart_evt),
    .sel      (idle_sel),
    .occupied (!q_empty),
    .expired  (timeout_irq)
  );

  hsrx_flow #(.CW(CW)) u_flow (
    .level    (fill_level),
    .trig_sel (trig_sel),
    .flow_en  (flow_en),
    .flow_sel (flow_sel),
    .flow_inv (flow_inv),
    .trig_hit (trig_irq),
    .rts_out  (rts_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun_irq <= 1'b0;
    else        overrun_irq <= drop_evt;
  end

  assign rd_word = pack_word(q_empty, head);

endmodule

// File: rtl/hsrx_queue_chk.sv
module hsrx_queue_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rd_en,
  input logic [31:0]   ctrl,
  input logic [31:0]   rd_word,
  input logic [CW-1:0] fill_level,
  input logic          trig_irq,
  input logic          timeout_irq,
  input logic          overrun_irq,
  input logic          rts_out
);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[31:11] == '0);

  assert_empty_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> (rd_word == 32'h0000_0100));

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CW'(DEPTH));

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_irq |-> ($past(rx_valid) && ($past(fill_level) == CW'(DEPTH))));

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_level == CW'(DEPTH)) && rx_valid && !rd_en) |=> (fill_level == CW'(DEPTH)));

  assert_trig_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4:2] == 3'd0) |-> (trig_irq == (fill_level != '0)));

  assert_trig_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == CW'(DEPTH)) |-> trig_irq);

  assert_tmo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[17:16] == 2'd0) |-> !timeout_irq);

  assert_tmo_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> !timeout_irq);

  assert_tmo_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !timeout_irq);

  assert_rts_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[18] && (fill_level == CW'(DEPTH))) |-> (rts_out == ctrl[21]));

  assert_rts_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[18] |-> (rts_out == !ctrl[21]));

endmodule

bind hsrx_queue hsrx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rd_en       (rd_en),
  .ctrl        (ctrl),
  .rd_word     (rd_word),
  .fill_level  (fill_level),
  .trig_irq    (trig_irq),
  .timeout_irq (timeout_irq),
  .overrun_irq (overrun_irq),
  .rts_out     (rts_out)
);

// File: tb/hsrx_queue_test.sv
module hsrx_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        os_tick = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ferr = 1'b0;
  logic        rx_brk = 1'b0;
  logic [31:0] ctrl = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_word;
  logic [6:0]  fill_level;
  logic        trig_irq, timeout_irq, overrun_irq, rts_out;
  logic [4:0]  sample_phase;

  int n_checks = 0;
  int n_fail   = 0;
  int pushed   = 0;
  logic [31:0] exp_words [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hsrx_queue uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .ctrl(ctrl),
    .rd_en(rd_en), .rd_word(rd_word), .fill_level(fill_level),
    .trig_irq(trig_irq), .timeout_irq(timeout_irq), .overrun_irq(overrun_irq),
    .rts_out(rts_out), .sample_phase(sample_phase)
  );

  // trig sel, rts sel, rts en, rts inv, target fill, expected trig, expected rts
  localparam logic [15:0] VEC [15] = '{
    {3'd0, 2'd0, 1'b1, 1'b0, 7'd0,  1'b0, 1'b1},
    {3'd0, 2'd0, 1'b1, 1'b0, 7'd1,  1'b1, 1'b1},
    {3'd1, 2'd0, 1'b1, 1'b1, 7'd3,  1'b0, 1'b0},
    {3'd1, 2'd0, 1'b1, 1'b0, 7'd4,  1'b1, 1'b1},
    {3'd2, 2'd0, 1'b1, 1'b0, 7'd7,  1'b0, 1'b1},
    {3'd2, 2'd0, 1'b1, 1'b0, 7'd8,  1'b1, 1'b0},
    {3'd3, 2'd1, 1'b1, 1'b0, 7'd15, 1'b0, 1'b1},
    {3'd3, 2'd1, 1'b1, 1'b0, 7'd16, 1'b1, 1'b0},
    {3'd4, 2'd2, 1'b0, 1'b0, 7'd31, 1'b0, 1'b1},
    {3'd4, 2'd2, 1'b1, 1'b0, 7'd31, 1'b0, 1'b1},
    {3'd4, 2'd2, 1'b1, 1'b0, 7'd32, 1'b1, 1'b0},
    {3'd5, 2'd3, 1'b1, 1'b1, 7'd47, 1'b0, 1'b0},
    {3'd5, 2'd3, 1'b1, 1'b0, 7'd48, 1'b1, 1'b0},
    {3'd6, 2'd3, 1'b0, 1'b1, 7'd48, 1'b1, 1'b0},
    {3'd7, 2'd3, 1'b1, 1'b0, 7'd64, 1'b1, 1'b0}
  };

  function automatic logic [31:0] mk_ctrl(input logic [2:0] tsel, input logic [1:0] tmo,
                                          input logic en, input logic [1:0] rsel,
                                          input logic inv, input logic [4:0] phase);
    logic [31:0] c;
    c = '0;
    c[4:2]   = tsel;
    c[13:9]  = phase;
    c[17:16] = tmo;
    c[18]    = en;
    c[20:19] = rsel;
    c[21]    = inv;
    return c;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic fe, input logic bk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop_check(input logic [31:0] exp, input string req);
    @(negedge clk);
    check(rd_word == exp, req, rd_word, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_model();
    logic [7:0] d;
    logic fe, bk;
    d  = 8'(pushed * 7 + 3);
    fe = (pushed % 3) == 0;
    bk = (pushed % 5) == 0;
    exp_words[pushed] = {21'b0, bk, fe, 1'b0, d};
    push(d, fe, bk);
    pushed++;
  endtask

  task automatic idle_case(input logic [1:0] tmo, input int chars, input string req);
    ctrl = mk_ctrl(3'd0, tmo, 1'b0, 2'd0, 1'b0, 5'd20);
    push(8'h3C, 1'b0, 1'b0);
    wait_cycles(chars * 140 - 5);
    check(timeout_irq == 1'b0, req, {31'b0, timeout_irq}, 32'd0);
    wait_cycles(10);
    check(timeout_irq == 1'b1, req, {31'b0, timeout_irq}, 32'd1);
    pop_check(32'h0000_003C, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    ctrl = mk_ctrl(3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd20);
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check(fill_level == 0, "R10 fill", 32'(fill_level), 0);
    check({trig_irq, timeout_irq, overrun_irq} == 3'b000, "R10 events",
          {29'b0, trig_irq, timeout_irq, overrun_irq}, 0);
    // R9 offset pass-through
    check(sample_phase == 5'd20, "R9 phase", 32'(sample_phase), 20);
    ctrl[13:9] = 5'd7;
    #1 check(sample_phase == 5'd7, "R9 phase", 32'(sample_phase), 7);

    // R2 empty read
    pop_check(32'h0000_0100, "R2 empty word");
    check(fill_level == 0, "R2 fill after empty read", 32'(fill_level), 0);

    // R5 / R8 table walk while filling
    for (int i = 0; i < 15; i++) begin
      logic [15:0] v;
      v = VEC[i];
      ctrl = mk_ctrl(v[15:13], 2'd0, v[10], v[12:11], v[9], 5'd20);
      while (pushed < int'(v[8:2])) push_model();
      #1;
      check(trig_irq == v[1], "R5 trigger", {31'b0, trig_irq}, {31'b0, v[1]});
      check(rts_out == v[0], "R8 rts", {31'b0, rts_out}, {31'b0, v[0]});
      check(fill_level == v[8:2], "R3 fill", 32'(fill_level), 32'(v[8:2]));
    end

    // R4 overrun while full
    check(overrun_irq == 1'b0, "R4 no overrun yet", {31'b0, overrun_irq}, 0);
    push(8'hEE, 1'b1, 1'b1);
    check(overrun_irq == 1'b1, "R4 overrun pulse", {31'b0, overrun_irq}, 1);
    check(fill_level == 7'd64, "R4 fill held", 32'(fill_level), 64);
    @(negedge clk);
    check(overrun_irq == 1'b0, "R4 pulse width", {31'b0, overrun_irq}, 0);

    // R1 / R3 drain in order
    for (int k = 0; k < DEPTH; k++) pop_check(exp_words[k], "R1 R3 drain word");
    check(fill_level == 0, "R3 drained", 32'(fill_level), 0);
    check(rd_word == 32'h100, "R2 empty after drain", rd_word, 32'h100);

    // R6 timeout lengths
    idle_case(2'd1, 4, "R6 four chars");
    check(timeout_irq == 1'b0, "R7 clear when empty", {31'b0, timeout_irq}, 0);
    idle_case(2'd2, 8, "R6 eight chars");
    idle_case(2'd3, 16, "R6 sixteen chars");

    // R6 disabled
    ctrl = mk_ctrl(3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 5'd20);
    push(8'h11, 1'b0, 1'b0);
    wait_cycles(700);
    check(timeout_irq == 1'b0, "R6 disabled", {31'b0, timeout_irq}, 0);
    pop_check(32'h11, "R6 disabled data");

    // R7 restart on character and on read
    ctrl = mk_ctrl(3'd0, 2'd1, 1'b0, 2'd0, 1'b0, 5'd20);
    push(8'h21, 1'b0, 1'b0);
    wait_cycles(400);
    push(8'h22, 1'b0, 1'b0);
    wait_cycles(400);
    check(timeout_irq == 1'b0, "R7 restart on char", {31'b0, timeout_irq}, 0);
    wait_cycles(200);
    check(timeout_irq == 1'b1, "R7 expiry", {31'b0, timeout_irq}, 1);
    pop_check(32'h21, "R7 read");
    check(timeout_irq == 1'b0, "R7 restart on read", {31'b0, timeout_irq}, 0);
    wait_cycles(553);
    check(timeout_irq == 1'b0, "R7 after read", {31'b0, timeout_irq}, 0);
    wait_cycles(10);
    check(timeout_irq == 1'b1, "R7 re-expiry", {31'b0, timeout_irq}, 1);
    pop_check(32'h22, "R7 last");

    // R7 never fires while empty
    wait_cycles(700);
    check(timeout_irq == 1'b0, "R7 empty idle", {31'b0, timeout_irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule